// File: doc/BRIEF.md
# Flash Protected-Range Access Gate

This block sits in front of a serial-flash cycle engine and decides, for every requested flash cycle, whether it may run. It holds a bank of protected-range words and a bank of flash-region words, both written through a plain configuration port. Every range and region is described in 4 KiB pages by a 14-bit base page and a 14-bit limit page. A protected range also has separate enables for read protection and write protection. Writes and both erase sizes are checked against write protection. Reads are checked against read protection.

A request arrives on a valid/ready interface. The request names a cycle kind, a byte address and a byte count minus one. The block accepts a request when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` stays low from the moment an allowed cycle is accepted until the engine reports completion on `spi_done`. A requester must hold its request stable while `req_ready` is low. An allowed request is passed to the engine as a one-cycle `spi_start` strobe. A blocked request never reaches the engine: the block reports completion and an access error itself, and stays ready for the next request.

A lockdown input freezes the protected-range words until reset. The block also decodes which flash regions are enabled.

Top module: `flash_guard`

## Requirements
- R1: A protected-range word uses these bits: bits 13:0 hold the base page, bit 15 enables read protection, bits 29:16 hold the limit page, and bit 31 enables write protection. The range covers bytes from base*4096 up to limit*4096+4095, both ends included.
- R2: A read request (kind 0) is blocked when its byte span, from addr to addr+len_m1, overlaps any range whose read-protect bit is set. A range that has only write protection does not block a read.
- R3: A write request (kind 1) is blocked when its byte span overlaps any range whose write-protect bit is set. A range that has only read protection does not block a write.
- R4: A protected range with neither enable bit set blocks nothing.
- R5: A blocked request is accepted at once. In the next cycle `cyc_done` and `acc_err` are both 1 for one cycle, and `spi_start` is never raised for that request.
- R6: An allowed request is handled as follows. In the next cycle `spi_start` is 1 for one cycle, and `spi_kind`, `spi_addr` and `spi_len_m1` carry the request. `req_ready` is 0 until the cycle after `spi_done` is seen. In that cycle `cyc_done` is 1 and `acc_err` is 0.
- R7: An erase of kind 2 is checked over the whole 4 KiB block that contains addr. An erase of kind 3 is checked over the whole 64 KiB block that contains addr. The length field is ignored for both erase kinds.
- R8: Once `lock_set` has been seen, `locked` stays 1 until reset. Protected-range writes are then ignored. Region words stay writable.
- R9: A flash-region word uses bits 13:0 for the base page and bits 29:16 for the limit page. `region_en[i]` is 0 when base >= limit, or when i > 0 and the limit is 0. Otherwise it is 1.
- R10: `cfg_rdata` shows the word selected by `cfg_bank` (0 = protected ranges, 1 = regions) and `cfg_idx`. Bits that the word does not define read 0.
- R11: After reset the outputs are as follows: `req_ready`=1; `spi_start`, `cyc_done`, `acc_err` and `locked` are all 0; all stored words are 0; and `region_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 1 | 0 selects protected ranges, 1 selects regions |
| cfg_idx | input | IDX_W | Index of the word in the bank |
| cfg_wdata | input | 32 | Word to write |
| cfg_rdata | output | 32 | Selected word, undefined bits read 0 |
| lock_set | input | 1 | Freezes protected ranges until reset |
| locked | output | 1 | Lockdown state |
| region_en | output | NUM_REGION | Per-region enable decode |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 2 | 0 read, 1 write, 2 erase 4 KiB, 3 erase 64 KiB |
| req_addr | input | 26 | Byte address |
| req_len_m1 | input | 6 | Byte count minus one |
| spi_start | output | 1 | One-cycle start to the engine |
| spi_kind | output | 2 | Kind of the started cycle |
| spi_addr | output | 26 | Address of the started cycle |
| spi_len_m1 | output | 6 | Length of the started cycle |
| spi_done | input | 1 | Engine has finished the started cycle |
| cyc_done | output | 1 | One-cycle completion pulse |
| acc_err | output | 1 | One-cycle access-error pulse, given together with cyc_done |

## Verification
The bench checks the edges of the ranges on both sides. It tests spans that end one byte before a range starts and spans that reach its first byte, as well as a span that runs past the top of the address space. A stored word with a wrong field position or a lost enable bit changes whether the cycle after acceptance shows `spi_start` or `acc_err`. A flaw in lockdown or write masking shows up on `cfg_rdata` straight away, before any request is made. A fault in the busy logic shows as `req_ready` going high too early, or as a second start while a cycle is still busy. The bench holds a request waiting during a busy cycle to catch this.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam int PAGE_W = 14;
  localparam int ADDR_W = PAGE_W + 12;
  localparam int LEN_W  = 6;
  localparam logic [31:0] PR_KEEP = 32'hBFFF_BFFF;
  localparam logic [31:0] RG_KEEP = 32'h3FFF_3FFF;
  typedef enum logic [1:0] {
    K_READ    = 2'd0,
    K_WRITE   = 2'd1,
    K_ERASE4K = 2'd2,
    K_ERASE64 = 2'd3
  } kind_e;
endpackage

// File: rtl/fg_pr_bank.sv
module fg_pr_bank #(
  parameter int NUM_PR = 5,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [31:0]             wr_data,
  input  logic                    lock_set,
  output logic                    locked,
  output logic [NUM_PR-1:0][31:0] pr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        locked <= 1'b0;
    else if (lock_set) locked <= 1'b1;
  end

  for (genvar i = 0; i < NUM_PR; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        pr_q[i] <= '0;
      else if (wr_en && !locked && wr_idx == IDX_W'(i))
        pr_q[i] <= wr_data & fg_pkg::PR_KEEP;
    end
  end

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  assert_locked_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(pr_q));
endmodule

// File: rtl/fg_region_bank.sv
module fg_region_bank #(
  parameter int NUM_REGION = 5,
  parameter int IDX_W      = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [31:0]                 wr_data,
  output logic [NUM_REGION-1:0][31:0] rg_q,
  output logic [NUM_REGION-1:0]       region_en
);
  for (genvar i = 0; i < NUM_REGION; i++) begin : g_region
    logic [13:0] base_pg, lim_pg;
    always_ff @(posedge clk) begin
      if (!rst_n)
        rg_q[i] <= '0;
      else if (wr_en && wr_idx == IDX_W'(i))
        rg_q[i] <= wr_data & fg_pkg::RG_KEEP;
    end
    assign base_pg = rg_q[i][13:0];
    assign lim_pg  = rg_q[i][29:16];
    if (i == 0) begin : g_first
      assign region_en[i] = base_pg < lim_pg;
    end else begin : g_rest
      assign region_en[i] = (base_pg < lim_pg) && (lim_pg != 14'd0);
    end
  end
endmodule

// File: rtl/fg_range_hit.sv
module fg_range_hit (
  input  logic        [31:0]          pr_word,
  input  logic                        is_read,
  input  logic [fg_pkg::ADDR_W:0]     span_lo,
  input  logic [fg_pkg::ADDR_W:0]     span_hi,
  output logic                        hit
);
  logic [fg_pkg::ADDR_W:0] r_lo, r_hi;
  logic                    armed;
  assign r_lo  = {1'b0, pr_word[13:0], 12'h000};
  assign r_hi  = {1'b0, pr_word[29:16], 12'hFFF};
  assign armed = is_read ? pr_word[15] : pr_word[31];
  assign hit   = armed && (span_lo <= r_hi) && (span_hi >= r_lo);
endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int NUM_PR     = 5,
  parameter int NUM_REGION = 5,
  localparam int NMAX  = (NUM_PR > NUM_REGION) ? NUM_PR : NUM_REGION,
  localparam int IDX_W = (NMAX > 1) ? $clog2(NMAX) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic                        cfg_bank,
  input  logic [IDX_W-1:0]            cfg_idx,
  input  logic [31:0]                 cfg_wdata,
  output logic [31:0]                 cfg_rdata,
  input  logic                        lock_set,
  output logic                        locked,
  output logic [NUM_REGION-1:0]       region_en,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [1:0]                  req_kind,
  input  logic [fg_pkg::ADDR_W-1:0]   req_addr,
  input  logic [fg_pkg::LEN_W-1:0]    req_len_m1,
  output logic                        spi_start,
  output logic [1:0]                  spi_kind,
  output logic [fg_pkg::ADDR_W-1:0]   spi_addr,
  output logic [fg_pkg::LEN_W-1:0]    spi_len_m1,
  input  logic                        spi_done,
  output logic                        cyc_done,
  output logic                        acc_err
);
  import fg_pkg::*;

  logic [NUM_PR-1:0][31:0]     pr_q;
  logic [NUM_REGION-1:0][31:0] rg_q;
  logic [NUM_PR-1:0]           hits;
  logic [ADDR_W:0]             span_lo, span_hi;
  logic                        is_read, blocked, accept, busy;

  fg_pr_bank #(.NUM_PR(NUM_PR), .IDX_W(IDX_W)) u_pr (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we && !cfg_bank), .wr_idx(cfg_idx),
    .wr_data(cfg_wdata), .lock_set(lock_set), .locked(locked), .pr_q(pr_q));

  fg_region_bank #(.NUM_REGION(NUM_REGION), .IDX_W(IDX_W)) u_rg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we && cfg_bank), .wr_idx(cfg_idx),
    .wr_data(cfg_wdata), .rg_q(rg_q), .region_en(region_en));

  always_comb begin
    cfg_rdata = '0;
    if (!cfg_bank) begin
      for (int i = 0; i < NUM_PR; i++)
        if (cfg_idx == IDX_W'(i)) cfg_rdata = pr_q[i];
    end else begin
      for (int i = 0; i < NUM_REGION; i++)
        if (cfg_idx == IDX_W'(i)) cfg_rdata = rg_q[i];
    end
  end

  // Byte span checked for the request; erase kinds widen to their block
  always_comb begin
    unique case (kind_e'(req_kind))
      K_ERASE4K: begin
        span_lo = {1'b0, req_addr[ADDR_W-1:12], 12'h000};
        span_hi = {1'b0, req_addr[ADDR_W-1:12], 12'hFFF};
      end
      K_ERASE64: begin
        span_lo = {1'b0, req_addr[ADDR_W-1:16], 16'h0000};
        span_hi = {1'b0, req_addr[ADDR_W-1:16], 16'hFFFF};
      end
      default: begin
        span_lo = {1'b0, req_addr};
        span_hi = {1'b0, req_addr} + {{(ADDR_W+1-LEN_W){1'b0}}, req_len_m1};
      end
    endcase
  end

  assign is_read = (kind_e'(req_kind) == K_READ);

  for (genvar i = 0; i < NUM_PR; i++) begin : g_hit
    fg_range_hit u_hit (.pr_word(pr_q[i]), .is_read(is_read),
      .span_lo(span_lo), .span_hi(span_hi), .hit(hits[i]));
  end

  assign blocked   = |hits;
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; spi_start <= 1'b0; cyc_done <= 1'b0; acc_err <= 1'b0;
      spi_kind <= '0; spi_addr <= '0; spi_len_m1 <= '0;
    end else begin
      spi_start <= 1'b0;
      cyc_done  <= 1'b0;
      acc_err   <= 1'b0;
      if (accept) begin
        if (blocked) begin
          cyc_done <= 1'b1;
          acc_err  <= 1'b1;
        end else begin
          busy       <= 1'b1;
          spi_start  <= 1'b1;
          spi_kind   <= req_kind;
          spi_addr   <= req_addr;
          spi_len_m1 <= req_len_m1;
        end
      end else if (busy && spi_done) begin
        busy     <= 1'b0;
        cyc_done <= 1'b1;
      end
    end
  end

  assert_err_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> !spi_start);
  assert_err_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> cyc_done);
  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |=> !spi_start);
  assert_start_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !req_ready);
endmodule

// File: tb/test_flash_guard.sv
`timescale 1ns/100ps
module test_flash_guard;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_bank = 0, lock_set = 0, req_valid = 0, spi_done = 0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic locked, req_ready, spi_start, cyc_done, acc_err;
  logic [4:0]  region_en;
  logic [1:0]  req_kind = '0, spi_kind;
  logic [25:0] req_addr = '0, spi_addr;
  logic [5:0]  req_len_m1 = '0, spi_len_m1;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  flash_guard i_flash_guard (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic bank, input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_bank = bank; cfg_idx = 3'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_read(input logic bank, input int idx, input logic [31:0] exp, input string tag);
    cfg_bank = bank; cfg_idx = 3'(idx);
    #1 chk(cfg_rdata, exp, tag);
  endtask

  task automatic issue(input logic [1:0] k, input logic [25:0] a, input logic [5:0] l,
                       input bit exp_block, input string tag);
    @(negedge clk);
    chk(32'(req_ready), 1, {tag, " ready before"});
    req_valid = 1; req_kind = k; req_addr = a; req_len_m1 = l;
    @(negedge clk);
    req_valid = 0;
    if (exp_block) begin
      chk(32'(spi_start), 0, {tag, " R5 no start"});
      chk(32'(acc_err), 1, {tag, " R5 err"});
      chk(32'(cyc_done), 1, {tag, " R5 done"});
    end else begin
      chk(32'(spi_start), 1, {tag, " R6 start"});
      chk(32'(acc_err), 0, {tag, " R6 no err"});
      chk(32'(spi_addr), 32'(a), {tag, " R6 addr"});
      chk(32'(spi_kind), 32'(k), {tag, " R6 kind"});
      chk(32'(req_ready), 0, {tag, " R6 busy"});
      spi_done = 1;
      @(negedge clk);
      spi_done = 0;
      chk(32'(cyc_done), 1, {tag, " R6 done"});
      chk(32'(acc_err), 0, {tag, " R6 done no err"});
    end
  endtask

  task automatic t_reset;
    chk(32'(req_ready), 1, "R11 ready");
    chk(32'(spi_start), 0, "R11 start");
    chk(32'(cyc_done), 0, "R11 done");
    chk(32'(acc_err), 0, "R11 err");
    chk(32'(locked), 0, "R11 locked");
    chk(32'(region_en), 0, "R11 region_en");
    cfg_read(0, 0, 0, "R11 pr0");
    cfg_read(1, 0, 0, "R11 rg0");
  endtask

  task automatic t_read_protect;
    cfg_write(0, 0, 32'h0011_8010);            // R1: pages 0x10..0x11, read protect
    issue(2'd0, 26'h000FFFC, 6'd3, 0, "R1 read ends below base");
    issue(2'd0, 26'h000FFFC, 6'd4, 1, "R1 R2 read touches base");
    issue(2'd0, 26'h0011FFF, 6'd0, 1, "R1 R2 read last byte");
    issue(2'd0, 26'h0012000, 6'd63, 0, "R1 read after limit");
    issue(2'd1, 26'h0010800, 6'd7, 0, "R3 write in read-only range");
  endtask

  task automatic t_write_protect;
    cfg_write(0, 1, 32'h8020_0020);            // page 0x20, write protect
    issue(2'd1, 26'h001FFF0, 6'd15, 0, "R3 write ends below");
    issue(2'd1, 26'h001FFF0, 6'd16, 1, "R3 write touches base");
    issue(2'd0, 26'h0020000, 6'd8, 0, "R2 read in write-only range");
    issue(2'd2, 26'h0020FFF, 6'd0, 1, "R7 erase4k inside");
    issue(2'd2, 26'h0021000, 6'd63, 0, "R7 erase4k next block");
    issue(2'd3, 26'h002F000, 6'd0, 1, "R7 erase64k covering");
    issue(2'd2, 26'h002F000, 6'd0, 0, "R7 erase4k same spot");
  endtask

  task automatic t_no_enable;
    cfg_write(0, 2, 32'h0030_0030);
    issue(2'd0, 26'h0030000, 6'd0, 0, "R4 read no enable");
    issue(2'd1, 26'h0030000, 6'd0, 0, "R4 write no enable");
  endtask

  task automatic t_top_and_mask;
    cfg_write(0, 4, 32'hFFFF_FFFF);
    cfg_read(0, 4, 32'hBFFF_BFFF, "R10 pr mask");
    issue(2'd0, 26'h3FFFFF0, 6'd63, 1, "R2 span past top");
    cfg_write(0, 4, 32'h4000_4000);
    cfg_read(0, 4, 32'h0, "R10 undefined bits");
    issue(2'd0, 26'h3FFFFF0, 6'd63, 0, "R10 cleared range");
  endtask

  task automatic t_regions;
    cfg_write(1, 0, 32'h0001_0000);
    cfg_write(1, 1, 32'h0000_0002);
    cfg_write(1, 2, 32'h0005_0005);
    cfg_write(1, 3, 32'h0006_0004);
    #1 chk(32'(region_en), 32'h09, "R9 region_en");
    cfg_write(1, 4, 32'hC005_C003);
    cfg_read(1, 4, 32'h0005_0003, "R10 rg mask");
    chk(32'(region_en), 32'h19, "R9 region_en after r4");
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    req_valid = 1; req_kind = 2'd0; req_addr = 26'h0040000; req_len_m1 = 6'd1;
    @(negedge clk);
    chk(32'(spi_start), 1, "R6 first start");
    req_addr = 26'h0050000;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk(32'(req_ready), 0, "R6 held not ready");
      chk(32'(spi_start), 0, "R6 no second start");
    end
    spi_done = 1;
    @(negedge clk);
    spi_done = 0;
    chk(32'(cyc_done), 1, "R6 first done");
    chk(32'(req_ready), 1, "R6 ready after done");
    @(negedge clk);
    req_valid = 0;
    chk(32'(spi_start), 1, "R6 waiting request starts");
    chk(32'(spi_addr), 32'h0050000, "R6 waiting addr");
    spi_done = 1;
    @(negedge clk);
    spi_done = 0;
  endtask

  task automatic t_lock;
    @(negedge clk);
    lock_set = 1;
    @(negedge clk);
    lock_set = 0;
    chk(32'(locked), 1, "R8 locked");
    cfg_write(0, 0, 32'h0);
    cfg_read(0, 0, 32'h0011_8010, "R8 pr frozen");
    issue(2'd0, 26'h0010000, 6'd0, 1, "R8 still blocks");
    cfg_write(1, 1, 32'h0003_0001);
    #1 chk(32'(region_en), 32'h1B, "R8 region writable");
    chk(32'(locked), 1, "R8 lock sticky");
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_protect();
    t_write_protect();
    t_no_enable();
    t_top_and_mask();
    t_regions();
    t_backpressure();
    t_lock();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule